// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a 32-bit processor core that fetches, decodes, executes and retires one instruction per clock. It runs a small load/store instruction set: five register-to-register operations (add, subtract, and, or, signed set-less-than), an OR with a zero-extended immediate, word load, word store, branch-if-equal and an absolute jump. The core holds the program counter, a 32-entry register file, the immediate extender and the ALU. Decoding is split in two levels. A main decoder turns the 6-bit opcode into datapath controls and a 3-bit ALU class. A local ALU decoder combines that class with the function field to pick one ALU operation.

Instruction memory and data memory are small word arrays inside the core. A test port writes either array and reads either array back without a clock. The intended use is to hold reset, load a program and its data through the test port, release reset and let the program run. Results are then read back from data memory through the same port.

Top module: `scpu_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and the core writes neither the register file nor data memory. Test-port writes still take effect during reset. After reset drops, the first rising edge moves the PC to 4.
- R2: The instruction word is split as opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and function [5:0], with immediate [15:0] and jump target [25:0]. Opcode 000000 is the register-to-register form. Function codes 100000 (add), 100010 (sub, rs minus rt), 100100 (and) and 100101 (or) write their result to register rd.
- R3: Opcode 001101 writes R[rs] OR the zero-extended immediate to register rt.
- R4: Opcode 100011 loads into rt the data-memory word at byte address R[rs] + sign-extended immediate. The word index is byte address bits [2+DMEM_AW-1:2].
- R5: Opcode 101011 stores R[rt] at byte address R[rs] + sign-extended immediate. No other opcode writes data memory.
- R6: Opcode 000100 compares R[rs] and R[rt] by subtraction. When they are equal, the next PC is PC+4 + (sign-extended immediate × 4); otherwise it is PC+4.
- R7: Opcode 000010 sets the next PC to {(PC+4)[31:28], target, 2'b00}.
- R8: Register 0 always reads as zero, and writes to it are dropped.
- R9: Any opcode not listed in R2–R7 writes neither the registers nor data memory, and the PC advances by 4.
- R10: Function code 101010 writes 1 to rd when R[rs] < R[rt] as signed two's-complement numbers, and 0 otherwise.
- R11: An instruction reads its source registers before its own write-back takes effect, so a destination that is also a source gets the result computed from the old value.
- R12: When `tp_we` is high, the rising edge writes `tp_wdata` to data memory if `tp_dmem` is 1, or to instruction memory if `tp_dmem` is 0, at word `tp_addr`. `tp_rdata` shows the word of the selected memory at `tp_addr` without a clock. A test-port write to data memory takes priority over a store in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tp_we | input | 1 | Test-port write enable |
| tp_dmem | input | 1 | Test-port memory select: 1 selects data memory, 0 selects instruction memory |
| tp_addr | input | TP_AW | Test-port word index |
| tp_wdata | input | 32 | Test-port write data |
| tp_rdata | output | 32 | Word of the selected memory at `tp_addr` |
| pc_o | output | 32 | Current program counter (byte address) |

## Verification
Two things happen at the same edge: the register write-back of one instruction and the operand read of the same register. This matters in two cases: an instruction whose destination is also its source, and a write aimed at register 0 followed by reads of it. The test program contains `add r1,r1,r1` and an add into r0, and later stores both registers to memory. The stored words are compared with values worked out by hand: the doubled old value, and zero over a pre-filled non-zero location. Taken and not-taken branches, a jump over poisoned instructions and an unknown opcode aimed at a marked memory word are judged the same way, by words that should or should not have changed.

// File: rtl/scpu_pkg.sv
package scpu_pkg;

    localparam int XLEN = 32;

    typedef logic [5:0] opcode_t;

    localparam opcode_t OP_REG  = 6'b000000;
    localparam opcode_t OP_ORI  = 6'b001101;
    localparam opcode_t OP_LOAD = 6'b100011;
    localparam opcode_t OP_STOR = 6'b101011;
    localparam opcode_t OP_BEQ  = 6'b000100;
    localparam opcode_t OP_JMP  = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    // ALU class produced by the main decoder
    typedef enum logic [2:0] {
        CLS_ADD   = 3'b000,
        CLS_SUB   = 3'b001,
        CLS_OR    = 3'b010,
        CLS_FUNCT = 3'b100
    } alu_cls_e;

    // Concrete ALU operation produced by the local decoder
    typedef enum logic [2:0] {
        ALU_ADD = 3'b000,
        ALU_SUB = 3'b001,
        ALU_AND = 3'b010,
        ALU_OR  = 3'b110,
        ALU_SLT = 3'b111
    } alu_sel_e;

    typedef struct packed {
        opcode_t     op;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [4:0]  rd;
        logic [5:0]  funct;
        logic [15:0] imm;
        logic [25:0] target;
    } fields_t;

    typedef struct packed {
        logic     reg_wr;
        logic     dst_rd;
        logic     src_imm;
        logic     ext_sign;
        logic     mem_to_reg;
        logic     mem_wr;
        logic     branch;
        logic     jump;
        alu_cls_e cls;
    } ctrl_t;

    function automatic fields_t split_word(logic [31:0] w);
        fields_t f;
        f.op     = w[31:26];
        f.rs     = w[25:21];
        f.rt     = w[20:16];
        f.rd     = w[15:11];
        f.funct  = w[5:0];
        f.imm    = w[15:0];
        f.target = w[25:0];
        return f;
    endfunction

    function automatic logic [XLEN-1:0] extend_imm(logic [15:0] imm, logic sgn);
        return {{(XLEN-16){sgn & imm[15]}}, imm};
    endfunction

endpackage

// File: rtl/scpu_main_dec.sv
module scpu_main_dec
    import scpu_pkg::*;
(
    input  opcode_t op,
    output ctrl_t   ctrl,
    output logic    known
);

    always_comb begin
        ctrl     = '0;
        ctrl.cls = CLS_ADD;
        known    = 1'b1;
        unique case (op)
            OP_REG: begin
                ctrl.reg_wr = 1'b1;
                ctrl.dst_rd = 1'b1;
                ctrl.cls    = CLS_FUNCT;
            end
            OP_ORI: begin
                ctrl.reg_wr  = 1'b1;
                ctrl.src_imm = 1'b1;
                ctrl.cls     = CLS_OR;
            end
            OP_LOAD: begin
                ctrl.reg_wr     = 1'b1;
                ctrl.src_imm    = 1'b1;
                ctrl.ext_sign   = 1'b1;
                ctrl.mem_to_reg = 1'b1;
            end
            OP_STOR: begin
                ctrl.src_imm  = 1'b1;
                ctrl.ext_sign = 1'b1;
                ctrl.mem_wr   = 1'b1;
            end
            OP_BEQ: begin
                ctrl.branch   = 1'b1;
                ctrl.ext_sign = 1'b1;
                ctrl.cls      = CLS_SUB;
            end
            OP_JMP: begin
                ctrl.jump = 1'b1;
            end
            default: begin
                known = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/scpu_alu_dec.sv
module scpu_alu_dec
    import scpu_pkg::*;
(
    input  alu_cls_e   cls,
    input  logic [5:0] funct,
    output alu_sel_e   sel
);

    always_comb begin
        unique case (cls)
            CLS_SUB: sel = ALU_SUB;
            CLS_OR:  sel = ALU_OR;
            CLS_FUNCT: begin
                unique case (funct)
                    FN_SUB:  sel = ALU_SUB;
                    FN_AND:  sel = ALU_AND;
                    FN_OR:   sel = ALU_OR;
                    FN_SLT:  sel = ALU_SLT;
                    default: sel = ALU_ADD;
                endcase
            end
            default: sel = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/scpu_alu.sv
module scpu_alu
    import scpu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_sel_e     sel,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        unique case (sel)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/scpu_regfile.sv
module scpu_regfile #(
    parameter int W      = 32,
    parameter int N_REGS = 32,
    localparam int AW    = $clog2(N_REGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs [N_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_REGS; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

    // a write aimed at register 0 leaves register 0 at zero on the next edge
    p_r0_write_dropped_r8: assert property (@(posedge clk) disable iff (rst)
        (we && wa == '0) |=> (regs[0] == '0));

endmodule

// File: rtl/scpu_core.sv
module scpu_core
    import scpu_pkg::*;
#(
    parameter int IMEM_AW = 6,
    parameter int DMEM_AW = 6,
    localparam int TP_AW  = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tp_we,
    input  logic             tp_dmem,
    input  logic [TP_AW-1:0] tp_addr,
    input  logic [31:0]      tp_wdata,
    output logic [31:0]      tp_rdata,
    output logic [31:0]      pc_o
);

    localparam int IMEM_WORDS = 1 << IMEM_AW;
    localparam int DMEM_WORDS = 1 << DMEM_AW;

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target, jmp_target;
    logic [XLEN-1:0] instr, imm_ext, opa, opb_reg, opb, alu_y, load_data, wb_data;
    logic            alu_zero, known, take_branch;
    logic [4:0]      wr_addr;
    logic [DMEM_AW-1:0] d_idx;
    fields_t         f;
    ctrl_t           ctrl;
    alu_sel_e        sel;

    // ---------------- fetch ----------------
    assign instr = imem[pc_q[2 +: IMEM_AW]];
    assign f     = split_word(instr);

    // ---------------- two-level decode ----------------
    scpu_main_dec u_main_dec (
        .op    (f.op),
        .ctrl  (ctrl),
        .known (known)
    );

    scpu_alu_dec u_alu_dec (
        .cls   (ctrl.cls),
        .funct (f.funct),
        .sel   (sel)
    );

    // ---------------- register file ----------------
    assign wr_addr = ctrl.dst_rd ? f.rd : f.rt;

    scpu_regfile #(.W(XLEN), .N_REGS(32)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_a (f.rs),
        .ra_b (f.rt),
        .rd_a (opa),
        .rd_b (opb_reg),
        .we   (ctrl.reg_wr & ~rst),
        .wa   (wr_addr),
        .wd   (wb_data)
    );

    // ---------------- execute ----------------
    assign imm_ext = extend_imm(f.imm, ctrl.ext_sign);
    assign opb     = ctrl.src_imm ? imm_ext : opb_reg;

    scpu_alu #(.W(XLEN)) u_alu (
        .a    (opa),
        .b    (opb),
        .sel  (sel),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // ---------------- memory and write-back ----------------
    assign d_idx     = alu_y[2 +: DMEM_AW];
    assign load_data = dmem[d_idx];
    assign wb_data   = ctrl.mem_to_reg ? load_data : alu_y;

    always_ff @(posedge clk) begin
        if (tp_we && tp_dmem)
            dmem[tp_addr[DMEM_AW-1:0]] <= tp_wdata;
        else if (!rst && ctrl.mem_wr)
            dmem[d_idx] <= opb_reg;
    end

    always_ff @(posedge clk) begin
        if (tp_we && !tp_dmem)
            imem[tp_addr[IMEM_AW-1:0]] <= tp_wdata;
    end

    assign tp_rdata = tp_dmem ? dmem[tp_addr[DMEM_AW-1:0]]
                              : imem[tp_addr[IMEM_AW-1:0]];

    // ---------------- next PC ----------------
    assign pc_plus4    = pc_q + 32'd4;
    assign br_target   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign jmp_target  = {pc_plus4[31:28], f.target, 2'b00};
    assign take_branch = ctrl.branch & alu_zero;

    always_comb begin
        if (ctrl.jump)        pc_next = jmp_target;
        else if (take_branch) pc_next = br_target;
        else                  pc_next = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign pc_o = pc_q;

    // ---------------- assertions ----------------
    p_reset_pc_r1: assert property (@(posedge clk)
        rst |=> (pc_q == '0));

    p_store_only_r5: assert property (@(posedge clk) disable iff (rst)
        ctrl.mem_wr |-> (f.op == OP_STOR));

    p_load_path_r4: assert property (@(posedge clk) disable iff (rst)
        ctrl.mem_to_reg |-> (ctrl.reg_wr && ctrl.ext_sign && !ctrl.dst_rd && sel == ALU_ADD));

    p_ori_zext_r3: assert property (@(posedge clk) disable iff (rst)
        (f.op == OP_ORI) |-> (opb[XLEN-1:16] == '0 && sel == ALU_OR && !ctrl.dst_rd));

    p_beq_subtract_r6: assert property (@(posedge clk) disable iff (rst)
        ctrl.branch |-> (sel == ALU_SUB && !ctrl.reg_wr));

    p_jump_target_r7: assert property (@(posedge clk) disable iff (rst)
        ctrl.jump |=> (pc_q == {$past(pc_q[31:28]), $past(f.target), 2'b00}));

    p_unknown_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !known |-> (!ctrl.reg_wr && !ctrl.mem_wr));

    p_pc_step_r9: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.jump && !ctrl.branch) |=> (pc_q == $past(pc_q) + 32'd4));

endmodule

// File: tb/test_scpu_core.sv
`timescale 1ns/1ps
module test_scpu_core;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          tp_we;
    logic          tp_dmem;
    logic [AW-1:0] tp_addr;
    logic [31:0]   tp_wdata;
    logic [31:0]   tp_rdata;
    logic [31:0]   pc_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    scpu_core #(.IMEM_AW(AW), .DMEM_AW(AW)) i_scpu_core (
        .clk(clk), .rst(rst), .tp_we(tp_we), .tp_dmem(tp_dmem),
        .tp_addr(tp_addr), .tp_wdata(tp_wdata), .tp_rdata(tp_rdata), .pc_o(pc_o)
    );

    // expected data-memory words after the program: {word index, value}
    localparam logic [63:0] EXP [12] = '{
        {32'd8,  32'h0000_8125},
        {32'd9,  32'h0000_0017},
        {32'd10, 32'h0000_0030},
        {32'd11, 32'h0000_80F5},
        {32'd12, 32'h0000_0001},
        {32'd13, 32'h0000_0000},
        {32'd14, 32'h0000_0000},
        {32'd15, 32'h0000_01E0},
        {32'd16, 32'h0000_0000},
        {32'd17, 32'h0000_0000},
        {32'd18, 32'h0000_8035},
        {32'd19, 32'h0000_55AA}
    };

    function automatic string tag_of(int idx);
        case (idx)
            0:  return "R2 add / R5 store";
            1:  return "R4 load sign-offset / R2 sub";
            2:  return "R2 and";
            3:  return "R2 or";
            4:  return "R10 slt true";
            5:  return "R10 slt false";
            6:  return "R8 r0 write dropped";
            7:  return "R11 read before write";
            8:  return "R6 taken branch skips";
            9:  return "R7 jump skips";
            10: return "R3 zero-extend";
            default: return "R9 unknown opcode quiet";
        endcase
    endfunction

    function automatic logic [31:0] rtype(int rs, int rt, int rd, logic [5:0] fn);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] itype(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] jtype(int tgt);
        return {6'b000010, 26'(tgt)};
    endfunction

    logic [31:0] prog [33];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tp_write(bit dsel, int idx, logic [31:0] val);
        @(negedge clk);
        tp_we = 1'b1; tp_dmem = dsel; tp_addr = AW'(idx); tp_wdata = val;
        @(negedge clk);
        tp_we = 1'b0;
    endtask

    task automatic tp_read(bit dsel, int idx, output logic [31:0] val);
        tp_dmem = dsel; tp_addr = AW'(idx);
        #1 val = tp_rdata;
    endtask

    initial begin
        logic [31:0] rv;
        rst = 1'b1; tp_we = 1'b0; tp_dmem = 1'b0; tp_addr = '0; tp_wdata = '0;

        prog[0]  = itype(6'b001101, 0, 1, 16'h00F0);      // ori r1 = 0xF0
        prog[1]  = itype(6'b001101, 0, 2, 16'h8035);      // ori r2 = 0x8035 (zero ext)
        prog[2]  = itype(6'b100011, 0, 3, 16'h0000);      // lw r3 = -16
        prog[3]  = itype(6'b100011, 0, 4, 16'h0004);      // lw r4 = 7
        prog[4]  = rtype(1, 2, 5, 6'b100000);             // add
        prog[5]  = rtype(4, 3, 6, 6'b100010);             // sub 7-(-16)
        prog[6]  = rtype(1, 2, 7, 6'b100100);             // and
        prog[7]  = rtype(1, 2, 8, 6'b100101);             // or
        prog[8]  = rtype(3, 4, 9, 6'b101010);             // slt -16<7
        prog[9]  = rtype(4, 3, 10, 6'b101010);            // slt 7<-16
        prog[10] = rtype(1, 1, 0, 6'b100000);             // write r0
        prog[11] = rtype(1, 1, 1, 6'b100000);             // r1 = r1+r1
        prog[12] = itype(6'b111111, 0, 12, 16'h004C);     // unknown opcode
        prog[13] = itype(6'b000100, 9, 4, 16'h0005);      // beq not taken
        prog[14] = itype(6'b000100, 10, 0, 16'h0002);     // beq taken -> 17
        prog[15] = itype(6'b001101, 0, 12, 16'h0BAD);
        prog[16] = itype(6'b001101, 0, 12, 16'h0BAD);
        prog[17] = jtype(20);
        prog[18] = itype(6'b001101, 0, 13, 16'h0BAD);
        prog[19] = itype(6'b001101, 0, 13, 16'h0BAD);
        prog[20] = itype(6'b001101, 0, 14, 16'h0040);     // base 0x40
        prog[21] = itype(6'b101011, 14, 5,  16'hFFE0);
        prog[22] = itype(6'b101011, 14, 6,  16'hFFE4);
        prog[23] = itype(6'b101011, 14, 7,  16'hFFE8);
        prog[24] = itype(6'b101011, 14, 8,  16'hFFEC);
        prog[25] = itype(6'b101011, 14, 9,  16'hFFF0);
        prog[26] = itype(6'b101011, 14, 10, 16'hFFF4);
        prog[27] = itype(6'b101011, 14, 0,  16'hFFF8);
        prog[28] = itype(6'b101011, 14, 1,  16'hFFFC);
        prog[29] = itype(6'b101011, 14, 12, 16'h0000);
        prog[30] = itype(6'b101011, 14, 13, 16'h0004);
        prog[31] = itype(6'b101011, 14, 2,  16'h0008);
        prog[32] = jtype(32);                             // halt loop

        // load under reset (R12, R1)
        for (int i = 0; i < 33; i++) tp_write(1'b0, i, prog[i]);
        tp_write(1'b1, 0, 32'hFFFF_FFF0);
        tp_write(1'b1, 1, 32'h0000_0007);
        tp_write(1'b1, 14, 32'h0000_DEAD);
        tp_write(1'b1, 19, 32'h0000_55AA);

        @(negedge clk);
        check("R1 pc during reset", pc_o, 32'h0);
        tp_read(1'b0, 5, rv);
        check("R12 imem readback", rv, prog[5]);
        tp_read(1'b1, 14, rv);
        check("R12 dmem load in reset", rv, 32'h0000_DEAD);

        rst = 1'b0;
        @(negedge clk);
        check("R1 first step pc", pc_o, 32'h4);

        repeat (60) @(negedge clk);
        check("R7 halt loop pc", pc_o, 32'h80);

        for (int k = 0; k < 12; k++) begin
            tp_read(1'b1, int'(EXP[k][63:32]), rv);
            check(tag_of(k), rv, EXP[k][31:0]);
        end

        // reset again returns PC to zero
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 pc after second reset", pc_o, 32'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule